// File: doc/BRIEF.md
# Token-Ring Depth-Cascaded FIFO

This block builds one deep first-in first-out queue out of a number of identical small storage slices. The slices are joined in a closed ring by two tokens: a write token and a read token. A single write port (enable and data) and a single read port (enable) are shared by every slice. On each accepted write, only the slice that holds the write token stores the word. On each accepted read, only the slice that holds the read token places its oldest word on the shared output. A slice hands the write token to the next slice in the ring in the same cycle that it writes its highest address. It hands the read token on in the same way when it reads its highest address. Every word therefore lives in exactly one slice. The words fill slice after slice in ring order, wrapping back to the first slice.

After reset, one designated first-load slice holds both tokens and all slices are empty. The handoff strobes are held inactive (high) for as long as reset is asserted. Four composite flags are produced by combining the per-slice flags. Full and almost-full assert only when every slice reports its own condition. Empty and almost-empty are formed the same way. A write while full and a read while empty are dropped. Both ports run from one clock. There is no retransmit and no half-full output.

Top module: `tokfifo_ring`

## Requirements
- R1: While reset is asserted and right after it is released, `empty`=1, `almost_empty`=1, `full`=0, `almost_full`=0 and `rd_data`=0. The slice selected by `FIRST_SLICE` holds both tokens.
- R2: Accepted writes fill one slice at a time. Write number n (counted from 0 after reset) goes to address n mod `SLICE_DEPTH` of slice (`FIRST_SLICE` + n / `SLICE_DEPTH`) mod `NUM_SLICES`. The write token moves to the next slice on the edge that ends the write to address `SLICE_DEPTH`-1, with no idle cycle in between. Reads leave the slices in the same order.
- R3: An accepted read loads `rd_data` with the oldest stored word on the clock edge that ends the read cycle. `rd_data` holds its value in every cycle without an accepted read. Words come out in write order across any number of trips around the ring.
- R4: `full` is 1 exactly when every slice holds `SLICE_DEPTH` words.
- R5: `empty` is 1 exactly when every slice holds zero words.
- R6: `almost_full` is 1 exactly when every slice holds at least `SLICE_DEPTH`-`AF_OFFSET` words.
- R7: `almost_empty` is 1 exactly when every slice holds at most `AE_OFFSET` words.
- R8: A write presented while `full`=1 is ignored: no word is stored and no flag changes because of it. A read in the same cycle is still accepted.
- R9: A read presented while `empty`=1 is ignored: `rd_data` and the flags stay unchanged. A write in the same cycle is still accepted.
- R10: When neither `full` nor `empty` is set, a write and a read in the same cycle are both accepted. The number of stored words is unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock shared by the write and read ports |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write request, common to all slices |
| wr_data | input | DATA_W | Write word, common to all slices |
| rd_en | input | 1 | Read request, common to all slices |
| rd_data | output | DATA_W | Registered read word from the slice that holds the read token |
| full | output | 1 | All slices full |
| empty | output | 1 | All slices empty |
| almost_full | output | 1 | All slices at or above their almost-full level |
| almost_empty | output | 1 | All slices at or below their almost-empty level |

## Verification
The bench drives the queue all the way to full and all the way to empty several times, so both tokens wrap past the last slice. A handoff that leaves a gap, or that sends the token to the wrong slice, shows up as a dropped or misordered word against the reference queue. The almost flags depend on how the words are spread across the slices. A design that places words in a different slice order gives almost-full or almost-empty values that differ from the per-slice counts in the model, even when the total is right. Writes hammered at a full queue and reads hammered at an empty one, with and without the other port active, catch a design that overwrites the oldest word, advances a token on a dropped request, or disturbs `rd_data` on an ignored read.

// File: rtl/tokfifo_pkg.sv
package tokfifo_pkg;

   // Width of a pointer into one slice of the given depth.
   function automatic int ptr_bits(input int depth);
      return (depth > 1) ? $clog2(depth) : 1;
   endfunction

   // Width of an occupancy count that can reach the full depth.
   function automatic int cnt_bits(input int depth);
      return $clog2(depth + 1);
   endfunction

   // Index of the ring neighbour that follows slice idx.
   function automatic int ring_next(input int idx, input int nslices);
      return (idx + 1) % nslices;
   endfunction

   // Index of the ring neighbour that precedes slice idx.
   function automatic int ring_prev(input int idx, input int nslices);
      return (idx + nslices - 1) % nslices;
   endfunction

endpackage

// File: rtl/tokfifo_slice.sv
module tokfifo_slice
   import tokfifo_pkg::*;
#(
   parameter int DATA_W      = 16,
   parameter int SLICE_DEPTH = 8,
   parameter int AF_OFFSET   = 2,
   parameter int AE_OFFSET   = 2,
   parameter bit IS_FIRST    = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_go,
   input  logic [DATA_W-1:0] wr_word,
   input  logic              rd_go,
   input  logic              w_in_n,
   input  logic              r_in_n,
   output logic              w_out_n,
   output logic              r_out_n,
   output logic              has_wtok,
   output logic              has_rtok,
   output logic              s_full,
   output logic              s_empty,
   output logic              s_afull,
   output logic              s_aempty,
   output logic [DATA_W-1:0] s_word
);

   localparam int AW = ptr_bits(SLICE_DEPTH);
   localparam int CW = cnt_bits(SLICE_DEPTH);
   localparam logic [AW-1:0] LAST_ADDR = AW'(SLICE_DEPTH - 1);
   localparam logic [CW-1:0] CNT_MAX   = CW'(SLICE_DEPTH);
   localparam logic [CW-1:0] AF_LEVEL  = CW'(SLICE_DEPTH - AF_OFFSET);
   localparam logic [CW-1:0] AE_LEVEL  = CW'(AE_OFFSET);

   logic [DATA_W-1:0] mem [SLICE_DEPTH];
   logic [AW-1:0]     wptr, rptr;
   logic [CW-1:0]     count;
   logic              wtok, rtok;
   logic              wr_here, rd_here;
   logic              w_wrap, r_wrap;

   assign wr_here = wr_go & wtok;
   assign rd_here = rd_go & rtok;
   assign w_wrap  = wr_here & (wptr == LAST_ADDR);
   assign r_wrap  = rd_here & (rptr == LAST_ADDR);

   // Handoff strobes: low for the cycle that uses the last address,
   // forced inactive while reset is held.
   assign w_out_n = ~(rst_n & w_wrap);
   assign r_out_n = ~(rst_n & r_wrap);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wtok  <= IS_FIRST;
         rtok  <= IS_FIRST;
         wptr  <= '0;
         rptr  <= '0;
         count <= '0;
      end else begin
         wtok <= (wtok & ~w_wrap) | ~w_in_n;
         rtok <= (rtok & ~r_wrap) | ~r_in_n;
         if (wr_here) wptr <= w_wrap ? '0 : wptr + 1'b1;
         if (rd_here) rptr <= r_wrap ? '0 : rptr + 1'b1;
         unique case ({wr_here, rd_here})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (wr_here) mem[wptr] <= wr_word;
   end

   assign s_word   = rtok ? mem[rptr] : '0;
   assign has_wtok = wtok;
   assign has_rtok = rtok;
   assign s_full   = (count == CNT_MAX);
   assign s_empty  = (count == '0);
   assign s_afull  = (count >= AF_LEVEL);
   assign s_aempty = (count <= AE_LEVEL);

   // R8
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_here |-> !s_full);

   // R9
   no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_here |-> !s_empty);

   // R2
   wtok_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (w_wrap && w_in_n) |=> !has_wtok);

endmodule

// File: rtl/tokfifo_flag_merge.sv
module tokfifo_flag_merge #(
   parameter int NUM_SLICES = 4
) (
   input  logic [NUM_SLICES-1:0] full_vec,
   input  logic [NUM_SLICES-1:0] empty_vec,
   input  logic [NUM_SLICES-1:0] afull_vec,
   input  logic [NUM_SLICES-1:0] aempty_vec,
   output logic                  full,
   output logic                  empty,
   output logic                  almost_full,
   output logic                  almost_empty
);

   // Per-slice flags in active-low form; a composite flag is active
   // only when no slice holds its active-low flag high.
   logic [NUM_SLICES-1:0] full_n, empty_n, afull_n, aempty_n;

   assign full_n   = ~full_vec;
   assign empty_n  = ~empty_vec;
   assign afull_n  = ~afull_vec;
   assign aempty_n = ~aempty_vec;

   assign full         = ~(|full_n);
   assign empty        = ~(|empty_n);
   assign almost_full  = ~(|afull_n);
   assign almost_empty = ~(|aempty_n);

endmodule

// File: rtl/tokfifo_rd_sel.sv
module tokfifo_rd_sel #(
   parameter int NUM_SLICES = 4,
   parameter int DATA_W     = 16
) (
   input  logic                                clk,
   input  logic                                rst_n,
   input  logic                                take,
   input  logic [NUM_SLICES-1:0][DATA_W-1:0]   words,
   output logic [DATA_W-1:0]                   rd_data
);

   logic [DATA_W-1:0] merged;

   // Slices without the read token present zero, so an OR of all
   // slice words acts as the shared bus.
   always_comb begin
      merged = '0;
      for (int i = 0; i < NUM_SLICES; i++) merged = merged | words[i];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    rd_data <= '0;
      else if (take) rd_data <= merged;
   end

   // R3
   rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !take |=> $stable(rd_data));

endmodule

// File: rtl/tokfifo_ring.sv
module tokfifo_ring
   import tokfifo_pkg::*;
#(
   parameter int DATA_W      = 16,
   parameter int NUM_SLICES  = 4,
   parameter int SLICE_DEPTH = 8,
   parameter int AF_OFFSET   = 2,
   parameter int AE_OFFSET   = 2,
   parameter int FIRST_SLICE = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_en,
   output logic [DATA_W-1:0] rd_data,
   output logic              full,
   output logic              empty,
   output logic              almost_full,
   output logic              almost_empty
);

   // Elaboration-time parameter checks
   if (DATA_W < 1) begin : g_bad_width
      $error("tokfifo_ring: DATA_W must be at least 1");
   end
   if (NUM_SLICES < 1) begin : g_bad_count
      $error("tokfifo_ring: NUM_SLICES must be at least 1");
   end
   if (SLICE_DEPTH < 2) begin : g_bad_depth
      $error("tokfifo_ring: SLICE_DEPTH must be at least 2");
   end
   if (AF_OFFSET < 0 || AF_OFFSET > SLICE_DEPTH) begin : g_bad_af
      $error("tokfifo_ring: AF_OFFSET out of range");
   end
   if (AE_OFFSET < 0 || AE_OFFSET > SLICE_DEPTH) begin : g_bad_ae
      $error("tokfifo_ring: AE_OFFSET out of range");
   end
   if (FIRST_SLICE < 0 || FIRST_SLICE >= NUM_SLICES) begin : g_bad_first
      $error("tokfifo_ring: FIRST_SLICE must name a slice");
   end

   logic                                wr_acc, rd_acc;
   logic [NUM_SLICES-1:0]               w_out_n, r_out_n;
   logic [NUM_SLICES-1:0]               wtok_vec, rtok_vec;
   logic [NUM_SLICES-1:0]               full_vec, empty_vec;
   logic [NUM_SLICES-1:0]               afull_vec, aempty_vec;
   logic [NUM_SLICES-1:0][DATA_W-1:0]   slice_word;

   assign wr_acc = wr_en & ~full;
   assign rd_acc = rd_en & ~empty;

   for (genvar i = 0; i < NUM_SLICES; i++) begin : g_slice
      localparam int PRV = ring_prev(i, NUM_SLICES);
      localparam int NXT = ring_next(i, NUM_SLICES);

      tokfifo_slice #(
         .DATA_W      (DATA_W),
         .SLICE_DEPTH (SLICE_DEPTH),
         .AF_OFFSET   (AF_OFFSET),
         .AE_OFFSET   (AE_OFFSET),
         .IS_FIRST    (i == FIRST_SLICE)
      ) u_slice (
         .clk      (clk),
         .rst_n    (rst_n),
         .wr_go    (wr_acc),
         .wr_word  (wr_data),
         .rd_go    (rd_acc),
         .w_in_n   (w_out_n[PRV]),
         .r_in_n   (r_out_n[PRV]),
         .w_out_n  (w_out_n[i]),
         .r_out_n  (r_out_n[i]),
         .has_wtok (wtok_vec[i]),
         .has_rtok (rtok_vec[i]),
         .s_full   (full_vec[i]),
         .s_empty  (empty_vec[i]),
         .s_afull  (afull_vec[i]),
         .s_aempty (aempty_vec[i]),
         .s_word   (slice_word[i])
      );

      // R2
      wtok_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !w_out_n[i] |=> wtok_vec[NXT]);

      // R2
      rtok_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !r_out_n[i] |=> rtok_vec[NXT]);
   end

   tokfifo_flag_merge #(
      .NUM_SLICES (NUM_SLICES)
   ) u_flags (
      .full_vec     (full_vec),
      .empty_vec    (empty_vec),
      .afull_vec    (afull_vec),
      .aempty_vec   (aempty_vec),
      .full         (full),
      .empty        (empty),
      .almost_full  (almost_full),
      .almost_empty (almost_empty)
   );

   tokfifo_rd_sel #(
      .NUM_SLICES (NUM_SLICES),
      .DATA_W     (DATA_W)
   ) u_rd_sel (
      .clk     (clk),
      .rst_n   (rst_n),
      .take    (rd_acc),
      .words   (slice_word),
      .rd_data (rd_data)
   );

   // R2
   tok_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($countones(wtok_vec) == 1) && ($countones(rtok_vec) == 1));

   // R4
   flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      full |-> !empty);

   // R8
   full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (full && !rd_en) |=> full);

   // R9
   empty_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (empty && !wr_en) |=> (empty && $stable(rd_data)));

endmodule

// File: tb/tokfifo_ring_tb.sv
module tokfifo_ring_tb;

   localparam int DW  = 16;
   localparam int NS  = 4;
   localparam int SD  = 8;
   localparam int AFO = 2;
   localparam int AEO = 2;
   localparam int FS  = 0;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic [DW-1:0] wr_data = '0;
   logic          rd_en = 1'b0;
   logic [DW-1:0] rd_data;
   logic          full, empty, almost_full, almost_empty;

   always #2.5 clk = ~clk;

   tokfifo_ring #(
      .DATA_W (DW), .NUM_SLICES (NS), .SLICE_DEPTH (SD),
      .AF_OFFSET (AFO), .AE_OFFSET (AEO), .FIRST_SLICE (FS)
   ) u_dut (
      .clk (clk), .rst_n (rst_n),
      .wr_en (wr_en), .wr_data (wr_data), .rd_en (rd_en),
      .rd_data (rd_data), .full (full), .empty (empty),
      .almost_full (almost_full), .almost_empty (almost_empty)
   );

   int            vectors = 0;
   int            miscompares = 0;
   bit            finished = 1'b0;

   // Behavioural reference
   logic [DW-1:0] q[$];
   int            cnt[NS];
   int            ws, wa, rs, ra;
   logic [DW-1:0] exp_rd;
   logic [15:0]   lfsr = 16'hACE1;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         miscompares++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic bit m_full();
      for (int i = 0; i < NS; i++) if (cnt[i] != SD) return 1'b0;
      return 1'b1;
   endfunction
   function automatic bit m_empty();
      for (int i = 0; i < NS; i++) if (cnt[i] != 0) return 1'b0;
      return 1'b1;
   endfunction
   function automatic bit m_afull();
      for (int i = 0; i < NS; i++) if (cnt[i] < SD - AFO) return 1'b0;
      return 1'b1;
   endfunction
   function automatic bit m_aempty();
      for (int i = 0; i < NS; i++) if (cnt[i] > AEO) return 1'b0;
      return 1'b1;
   endfunction

   task automatic model_reset();
      q.delete();
      for (int i = 0; i < NS; i++) cnt[i] = 0;
      ws = FS; wa = 0; rs = FS; ra = 0;
      exp_rd = '0;
   endtask

   task automatic compare_all(input string tag);
      chk({"R3 rd_data ", tag}, 32'(rd_data), 32'(exp_rd));
      chk({"R4 full ", tag}, 32'(full), 32'(m_full()));
      chk({"R5 empty ", tag}, 32'(empty), 32'(m_empty()));
      chk({"R2 R6 almost_full ", tag}, 32'(almost_full), 32'(m_afull()));
      chk({"R2 R7 almost_empty ", tag}, 32'(almost_empty), 32'(m_aempty()));
   endtask

   // Called at a falling edge; returns at the next falling edge.
   task automatic step(input bit we, input logic [DW-1:0] wd, input bit re, input string tag);
      bit acc_w, acc_r;
      wr_en = we; wr_data = wd; rd_en = re;
      acc_w = we && !m_full();
      acc_r = re && !m_empty();
      @(posedge clk);
      #1;
      if (acc_r) begin
         exp_rd = q.pop_front();
         cnt[rs]--;
         ra++;
         if (ra == SD) begin ra = 0; rs = (rs + 1) % NS; end
      end
      if (acc_w) begin
         q.push_back(wd);
         cnt[ws]++;
         wa++;
         if (wa == SD) begin wa = 0; ws = (ws + 1) % NS; end
      end
      compare_all(tag);
      @(negedge clk);
      wr_en = 1'b0; rd_en = 1'b0;
   endtask

   function automatic logic [15:0] lfsr_next(input logic [15:0] v);
      return {v[14:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
   endfunction

   initial begin
      model_reset();
      repeat (3) @(negedge clk);
      // R1: values during reset
      chk("R1 empty in reset", 32'(empty), 32'd1);
      chk("R1 full in reset", 32'(full), 32'd0);
      chk("R1 almost_empty in reset", 32'(almost_empty), 32'd1);
      chk("R1 almost_full in reset", 32'(almost_full), 32'd0);
      chk("R1 rd_data in reset", 32'(rd_data), 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      compare_all("R1 after release");

      // Fill the whole ring; R2 placement seen through the almost flags
      for (int n = 0; n < NS * SD; n++) begin
         lfsr = lfsr_next(lfsr);
         step(1'b1, lfsr, 1'b0, "R2 fill");
      end
      chk("R4 full after fill", 32'(full), 32'd1);

      // R8: writes against a full ring, alone and with a read
      for (int n = 0; n < 5; n++) step(1'b1, 16'hDEAD, 1'b0, "R8 write while full");
      step(1'b1, 16'hBEEF, 1'b1, "R8 write+read while full");
      step(1'b1, 16'h1234, 1'b0, "R8 refill one");

      // Drain and over-read: R9
      for (int n = 0; n < NS * SD + 6; n++) step(1'b0, '0, 1'b1, "R9 drain");
      chk("R9 empty after drain", 32'(empty), 32'd1);
      step(1'b1, 16'h5A5A, 1'b1, "R9 read+write while empty");
      step(1'b0, '0, 1'b1, "R9 read back");

      // R10: steady simultaneous traffic at mid occupancy
      for (int n = 0; n < 12; n++) begin
         lfsr = lfsr_next(lfsr);
         step(1'b1, lfsr, 1'b0, "R10 prefill");
      end
      for (int n = 0; n < 3 * NS * SD; n++) begin
         lfsr = lfsr_next(lfsr);
         step(1'b1, lfsr, 1'b1, "R10 write+read");
      end

      // Mixed traffic with changing bias: many ring trips, R3 ordering
      for (int blk = 0; blk < 16; blk++) begin
         int wbias;
         wbias = (blk % 4 == 0) ? 13 : (blk % 4 == 1) ? 3 : (blk % 4 == 2) ? 8 : 11;
         for (int n = 0; n < 150; n++) begin
            bit we, re;
            lfsr = lfsr_next(lfsr);
            we = (lfsr[3:0] < 4'(wbias));
            re = (lfsr[7:4] >= 4'(wbias));
            if (lfsr[11:8] == 4'hF) begin we = 1'b1; re = 1'b1; end
            step(we, {lfsr[7:0], lfsr[15:8]}, re, "R3 mixed");
         end
      end

      // Final drain checks order of everything left
      for (int n = 0; n < NS * SD + 2; n++) step(1'b0, '0, 1'b1, "R3 final drain");
      chk("R5 empty at end", 32'(empty), 32'd1);

      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin
      #(5.0 * 20000);
      if (!finished) begin
         miscompares++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

endmodule